// File: doc/BRIEF.md
# Flash command sequencer

This block is the write-side control logic of a behavioural model of a dual-bank NOR flash. It watches the bus write cycles and decodes the command sequences written to it. A standard program takes four writes. A program in the shortened bypass mode takes two. The block also handles autoselect entry, sector erase and chip erase. For each program or erase it reports a busy pulse on the bank that holds the target address, so that a reader can keep reading from the other bank.

The block also has a fast-program input, a write-protect input, and a choice of 16-bit or 32-bit program width. The memory array, the analog timing and the erase algorithms are outside the block. A program or erase shows only as a busy pulse of fixed length, plus a one-cycle program strobe that carries the address and the data.

Top module: `flash_cmd_seq`

## Requirements
- R1: A write cycle is taken only when ce_n=0, we_n=0 and oe_n=1 all hold. The block takes one command per entry into that condition, however many clocks the condition lasts.
- R2: The writes 0x555/0xAA, 0x2AA/0x55, 0x555/0xA0 and then address/data produce pgm_stb for exactly one cycle, in the cycle after the clock edge that samples the fourth write. In that cycle pgm_addr and pgm_data carry the fourth write's address and data. Command addresses are compared on addr[10:0] and command codes on wdata[7:0].
- R3: The writes 0x555/0xAA, 0x2AA/0x55, 0x555/0x20 enter bypass mode (byp_mode=1). In bypass mode a write of 0xA0 at any address, followed by address/data, programs. A write of 0x90 followed by a write of 0x00 leaves bypass mode. Any other second write after 0x90 leaves the block in bypass mode.
- R4: While acc_hi=1, byp_mode reads 1 and the two-write bypass program works with no unlock writes. Bypass mode cannot be left while acc_hi=1.
- R5: When x16=1, pgm_data is {16'h0, wdata[15:0]}. When x16=0, pgm_data is the whole 32-bit wdata.
- R6: The writes 0x555/0xAA, 0x2AA/0x55, 0x555/0x90 set asel_mode. While asel_mode=1, asel_code shows MFR_CODE for addr[1:0]=0, DEV_CODE for addr[1:0]=1, 0x01 or 0x00 (addressed sector protected or not) for addr[1:0]=2, and 0x00 otherwise. A write of 0xF0 clears asel_mode. asel_mode and byp_mode are never 1 together.
- R7: Bank select uses addr[AW-1:AW-2]. With TOP_BOOT=1, the value 00 selects bank 0 and every other value selects bank 1. With TOP_BOOT=0, the value 11 selects bank 1 and every other value selects bank 0.
- R8: A program sets bank_busy of the target bank alone for exactly PGM_CYC cycles, starting in the same cycle as pgm_stb.
- R9: The writes 0x555/0xAA, 0x2AA/0x55, 0x555/0x80, 0x555/0xAA, 0x2AA/0x55, then sector address/0x30, make the target bank busy for ERS_CYC cycles. If the last write is 0x555/0x10 instead, both banks are busy for ERS_CYC cycles.
- R10: While wp_n=0, the protected sector (addr[AW-1:SEC_LSB] all ones when TOP_BOOT=1, all zeros when TOP_BOOT=0) receives no strobe and raises no busy, for normal programs, accelerated programs and sector erases alike.
- R11: An address/data pair that does not fit the current sequence sends the block back to read mode (or to bypass idle while in bypass mode), with no strobe and no busy. 0xF0 sends the block back to read mode.
- R12: While either bank is busy, writes are ignored and the sequence state does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | AW | Word address |
| wdata | input | 32 | Write data |
| x16 | input | 1 | 1 selects 16-bit program width |
| acc_hi | input | 1 | Fast-program level present |
| wp_n | input | 1 | Write protect, active low |
| pgm_stb | output | 1 | One-cycle program strobe |
| pgm_addr | output | AW | Program target address |
| pgm_data | output | 32 | Program data |
| bank_busy | output | 2 | Busy flag for each bank |
| byp_mode | output | 1 | Bypass mode active |
| asel_mode | output | 1 | Autoselect mode active |
| asel_code | output | 8 | Autoselect code for the current address |

## Verification
The assertions assume the bus stays synchronous to clk, with every control and address change seen on at least one clock edge. They also assume wp_n is steady for the whole clock in which a program's last write is sampled. The stimulus drives every input one time unit after a rising edge and holds write cycles for at least one clock. It changes wp_n and acc_hi only between sequences, never during a write. It waits out each busy window before a new sequence, except in the one test that writes into the busy window on purpose.

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq #(
  parameter int         AW       = 19,
  parameter int         SEC_LSB  = 12,
  parameter int         PGM_CYC  = 8,
  parameter int         ERS_CYC  = 24,
  parameter bit         TOP_BOOT = 1'b1,
  parameter logic [7:0] MFR_CODE = 8'h01,
  parameter logic [7:0] DEV_CODE = 8'h3A
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_n,
  input  logic          we_n,
  input  logic          oe_n,
  input  logic [AW-1:0] addr,
  input  logic [31:0]   wdata,
  input  logic          x16,
  input  logic          acc_hi,
  input  logic          wp_n,
  output logic          pgm_stb,
  output logic [AW-1:0] pgm_addr,
  output logic [31:0]   pgm_data,
  output logic [1:0]    bank_busy,
  output logic          byp_mode,
  output logic          asel_mode,
  output logic [7:0]    asel_code
);
  localparam int CMAX = (PGM_CYC > ERS_CYC) ? PGM_CYC : ERS_CYC;
  localparam int CW   = $clog2(CMAX + 1);
  localparam int SW   = AW - SEC_LSB;
  localparam logic [SW-1:0] PSEC = TOP_BOOT ? {SW{1'b1}} : {SW{1'b0}};

  typedef enum logic [3:0] {
    S_RD, S_U1, S_U2, S_PG, S_E0, S_E1, S_E2, S_AS, S_BY, S_BPG, S_BEX
  } st_t;

  st_t  st, cur, nxt;
  logic wr_q, wr_on, wr_evt;
  logic do_pgm, do_sect, do_chip;

  wire [7:0] cmd      = wdata[7:0];
  wire       a555     = addr[10:0] == 11'h555;
  wire       a2aa     = addr[10:0] == 11'h2AA;
  wire       tgt_bank = TOP_BOOT ? (addr[AW-1:AW-2] != 2'b00) : (addr[AW-1:AW-2] == 2'b11);
  wire       prot_hit = ~wp_n & (addr[AW-1:SEC_LSB] == PSEC);
  wire       in_byp   = (st == S_BY) | (st == S_BPG) | (st == S_BEX);

  assign wr_on     = ~ce_n & ~we_n & oe_n;
  assign wr_evt    = wr_on & ~wr_q & ~(|bank_busy);
  assign cur       = (acc_hi & ~in_byp) ? S_BY : st;
  assign byp_mode  = in_byp | acc_hi;
  assign asel_mode = (st == S_AS) & ~acc_hi;

  always_comb begin
    nxt     = S_RD;
    do_pgm  = 1'b0;
    do_sect = 1'b0;
    do_chip = 1'b0;
    case (cur)
      S_RD:  if (a555 && cmd == 8'hAA) nxt = S_U1;
      S_U1:  if (a2aa && cmd == 8'h55) nxt = S_U2;
      S_U2:  if (a555) begin
               case (cmd)
                 8'hA0:   nxt = S_PG;
                 8'h90:   nxt = S_AS;
                 8'h20:   nxt = S_BY;
                 8'h80:   nxt = S_E0;
                 default: nxt = S_RD;
               endcase
             end
      S_PG:  do_pgm = 1'b1;
      S_E0:  if (a555 && cmd == 8'hAA) nxt = S_E1;
      S_E1:  if (a2aa && cmd == 8'h55) nxt = S_E2;
      S_E2:  begin
               do_sect = cmd == 8'h30;
               do_chip = a555 && cmd == 8'h10;
             end
      S_AS:  nxt = (cmd == 8'hF0) ? S_RD : S_AS;
      S_BY:  nxt = (cmd == 8'hA0) ? S_BPG : (cmd == 8'h90) ? S_BEX : S_BY;
      S_BPG: begin
               do_pgm = 1'b1;
               nxt    = S_BY;
             end
      S_BEX: nxt = (cmd == 8'h00 && !acc_hi) ? S_RD : S_BY;
      default: nxt = S_RD;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_RD;
      wr_q     <= 1'b0;
      pgm_stb  <= 1'b0;
      pgm_addr <= '0;
      pgm_data <= '0;
    end else begin
      wr_q    <= wr_on;
      pgm_stb <= wr_evt & do_pgm & ~prot_hit;
      if (wr_evt) st <= nxt;
      if (wr_evt & do_pgm & ~prot_hit) begin
        pgm_addr <= addr;
        pgm_data <= x16 ? {16'h0, wdata[15:0]} : wdata;
      end
    end
  end

  for (genvar b = 0; b < 2; b++) begin : g_bank
    logic [CW-1:0] cnt;
    wire mine = (tgt_bank == 1'(b)) & ~prot_hit;
    wire load = wr_evt & (do_chip | ((do_pgm | do_sect) & mine));
    always_ff @(posedge clk) begin
      if (!rst_n)          cnt <= '0;
      else if (load)       cnt <= do_pgm ? CW'(PGM_CYC) : CW'(ERS_CYC);
      else if (cnt != '0)  cnt <= cnt - 1'b1;
    end
    assign bank_busy[b] = cnt != '0;
  end

  always_comb begin
    asel_code = 8'h00;
    if (asel_mode) begin
      case (addr[1:0])
        2'd0:    asel_code = MFR_CODE;
        2'd1:    asel_code = DEV_CODE;
        2'd2:    asel_code = {7'b0, prot_hit};
        default: asel_code = 8'h00;
      endcase
    end
  end
endmodule

// File: rtl/flash_cmd_seq_chk.sv
module flash_cmd_seq_chk #(
  parameter int AW       = 19,
  parameter int SEC_LSB  = 12,
  parameter bit TOP_BOOT = 1'b1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ce_n,
  input logic          we_n,
  input logic          oe_n,
  input logic          wp_n,
  input logic          pgm_stb,
  input logic [AW-1:0] pgm_addr,
  input logic [1:0]    bank_busy,
  input logic          byp_mode,
  input logic          asel_mode
);
  localparam int SW = AW - SEC_LSB;
  localparam logic [SW-1:0] PSEC = TOP_BOOT ? {SW{1'b1}} : {SW{1'b0}};

  // R1
  wr_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!ce_n && !we_n && oe_n) |=> !pgm_stb);

  // R2
  stb_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pgm_stb |=> !pgm_stb);

  // R8
  stb_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pgm_stb |-> $countones(bank_busy) == 1);

  // R12
  busy_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|bank_busy) |=> !pgm_stb);

  // R10
  prot_sector_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pgm_stb |-> ($past(wp_n) || pgm_addr[AW-1:SEC_LSB] != PSEC));

  // R6
  mode_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(asel_mode && byp_mode));
endmodule

bind flash_cmd_seq flash_cmd_seq_chk #(.AW(AW), .SEC_LSB(SEC_LSB), .TOP_BOOT(TOP_BOOT)) u_chk (
  .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n), .wp_n(wp_n),
  .pgm_stb(pgm_stb), .pgm_addr(pgm_addr), .bank_busy(bank_busy),
  .byp_mode(byp_mode), .asel_mode(asel_mode)
);

// File: tb/flash_cmd_seq_tb.sv
module flash_cmd_seq_ref #(
  parameter int AW = 19, parameter int SEC_LSB = 12,
  parameter int PGM_CYC = 6, parameter int ERS_CYC = 14, parameter bit TOP_BOOT = 1'b1
) (
  input  logic clk, input logic rst_n, input logic ce_n, input logic we_n, input logic oe_n,
  input  logic [AW-1:0] addr, input logic [31:0] wdata,
  input  logic x16, input logic acc_hi, input logic wp_n,
  output logic e_stb, output logic [AW-1:0] e_addr, output logic [31:0] e_data,
  output logic [1:0] e_busy, output logic e_byp, output logic e_asel
);
  logic [10:0] qa[$];
  logic [7:0]  qd[$];
  bit byp, asel, prev, cond, busy, ok;
  int bpend, n;
  int cnt[2];

  function automatic int bank_of(logic [AW-1:0] a);
    if (TOP_BOOT) return (a[AW-1:AW-2] == 2'b00) ? 0 : 1;
    return (a[AW-1:AW-2] == 2'b11) ? 1 : 0;
  endfunction

  function automatic bit is_prot(logic [AW-1:0] a, logic wp);
    int sec = int'(a >> SEC_LSB);
    if (wp) return 0;
    return TOP_BOOT ? (sec == (1 << (AW - SEC_LSB)) - 1) : (sec == 0);
  endfunction

  task automatic do_program();
    if (!is_prot(addr, wp_n)) begin
      e_stb  = 1;
      e_addr = addr;
      e_data = x16 ? (wdata & 32'h0000FFFF) : wdata;
      cnt[bank_of(addr)] = PGM_CYC;
    end
  endtask

  assign e_byp  = byp || acc_hi;
  assign e_asel = asel && !acc_hi;

  always @(posedge clk) begin
    if (!rst_n) begin
      qa.delete(); qd.delete();
      byp = 0; asel = 0; prev = 0; bpend = 0; cnt[0] = 0; cnt[1] = 0;
      e_stb = 0; e_addr = '0; e_data = '0;
    end else begin
      cond = !ce_n && !we_n && oe_n;
      busy = cnt[0] > 0 || cnt[1] > 0;
      e_stb = 0;
      for (int b = 0; b < 2; b++) if (cnt[b] > 0) cnt[b]--;
      if (cond && !prev && !busy) begin
        if (acc_hi && !byp) begin
          byp = 1; asel = 0; bpend = 0; qa.delete(); qd.delete();
        end
        if (byp) begin
          if (bpend == 1) begin do_program(); bpend = 0; end
          else if (bpend == 2) begin
            if (wdata[7:0] == 8'h00 && !acc_hi) byp = 0;
            bpend = 0;
          end
          else if (wdata[7:0] == 8'hA0) bpend = 1;
          else if (wdata[7:0] == 8'h90) bpend = 2;
        end else if (asel) begin
          if (wdata[7:0] == 8'hF0) asel = 0;
        end else begin
          qa.push_back(addr[10:0]);
          qd.push_back(wdata[7:0]);
          n = qa.size();
          ok = 0;
          case (n)
            1: ok = qa[0] == 11'h555 && qd[0] == 8'hAA;
            2: ok = qa[1] == 11'h2AA && qd[1] == 8'h55;
            3: if (qa[2] == 11'h555) begin
                 if (qd[2] == 8'hA0 || qd[2] == 8'h80) ok = 1;
                 else if (qd[2] == 8'h90) asel = 1;
                 else if (qd[2] == 8'h20) byp = 1;
               end
            4: if (qd[2] == 8'hA0) do_program();
               else ok = qa[3] == 11'h555 && qd[3] == 8'hAA;
            5: ok = qa[4] == 11'h2AA && qd[4] == 8'h55;
            6: if (qd[5] == 8'h30) begin
                 if (!is_prot(addr, wp_n)) cnt[bank_of(addr)] = ERS_CYC;
               end else if (qa[5] == 11'h555 && qd[5] == 8'h10) begin
                 cnt[0] = ERS_CYC; cnt[1] = ERS_CYC;
               end
            default: ok = 0;
          endcase
          if (!ok) begin qa.delete(); qd.delete(); end
        end
      end
      prev = cond;
    end
    e_busy = {cnt[1] > 0, cnt[0] > 0};
  end
endmodule

module flash_cmd_seq_tb;
  localparam int AW = 19, SEC_LSB = 12, PGM_CYC = 6, ERS_CYC = 14;

  logic clk = 0, rst_n = 0, ce_n = 1, we_n = 1, oe_n = 1;
  logic [AW-1:0] addr = '0;
  logic [31:0] wdata = '0;
  logic x16 = 0, acc_hi = 0, wp_n = 1;

  logic t_stb, b_stb, t_byp, b_byp, t_asel, b_asel;
  logic [AW-1:0] t_addr, b_addr;
  logic [31:0] t_data, b_data;
  logic [1:0] t_busy, b_busy;
  logic [7:0] t_code, b_code;
  logic rt_stb, rb_stb, rt_byp, rb_byp, rt_asel, rb_asel;
  logic [AW-1:0] rt_addr, rb_addr;
  logic [31:0] rt_data, rb_data;
  logic [1:0] rt_busy, rb_busy;

  int vectors = 0, miscompares = 0, stb_seen = 0;
  logic [AW-1:0] last_addr;
  logic [31:0] last_data;
  logic [1:0] last_bt, last_bb;
  bit done = 0;

  always #10 clk = ~clk;

  flash_cmd_seq #(.AW(AW), .SEC_LSB(SEC_LSB), .PGM_CYC(PGM_CYC), .ERS_CYC(ERS_CYC), .TOP_BOOT(1'b1)) u_dut (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n), .addr(addr), .wdata(wdata),
    .x16(x16), .acc_hi(acc_hi), .wp_n(wp_n), .pgm_stb(t_stb), .pgm_addr(t_addr), .pgm_data(t_data),
    .bank_busy(t_busy), .byp_mode(t_byp), .asel_mode(t_asel), .asel_code(t_code));

  flash_cmd_seq #(.AW(AW), .SEC_LSB(SEC_LSB), .PGM_CYC(PGM_CYC), .ERS_CYC(ERS_CYC), .TOP_BOOT(1'b0)) u_dut_bot (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n), .addr(addr), .wdata(wdata),
    .x16(x16), .acc_hi(acc_hi), .wp_n(wp_n), .pgm_stb(b_stb), .pgm_addr(b_addr), .pgm_data(b_data),
    .bank_busy(b_busy), .byp_mode(b_byp), .asel_mode(b_asel), .asel_code(b_code));

  flash_cmd_seq_ref #(.AW(AW), .SEC_LSB(SEC_LSB), .PGM_CYC(PGM_CYC), .ERS_CYC(ERS_CYC), .TOP_BOOT(1'b1)) u_ref_top (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n), .addr(addr), .wdata(wdata),
    .x16(x16), .acc_hi(acc_hi), .wp_n(wp_n), .e_stb(rt_stb), .e_addr(rt_addr), .e_data(rt_data),
    .e_busy(rt_busy), .e_byp(rt_byp), .e_asel(rt_asel));

  flash_cmd_seq_ref #(.AW(AW), .SEC_LSB(SEC_LSB), .PGM_CYC(PGM_CYC), .ERS_CYC(ERS_CYC), .TOP_BOOT(1'b0)) u_ref_bot (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n), .addr(addr), .wdata(wdata),
    .x16(x16), .acc_hi(acc_hi), .wp_n(wp_n), .e_stb(rb_stb), .e_addr(rb_addr), .e_data(rb_data),
    .e_busy(rb_busy), .e_byp(rb_byp), .e_asel(rb_asel));

  function automatic logic [7:0] code_exp(logic asel, bit top, logic [AW-1:0] a, logic wp);
    int sec = int'(a >> SEC_LSB);
    bit p = !wp && (top ? (sec == (1 << (AW - SEC_LSB)) - 1) : (sec == 0));
    if (!asel) return 8'h00;
    case (a[1:0])
      2'd0: return 8'h01;
      2'd1: return 8'h3A;
      2'd2: return p ? 8'h01 : 8'h00;
      default: return 8'h00;
    endcase
  endfunction

  task automatic chk(bit ok, string tag, longint act, longint exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(t_stb == rt_stb, "R2 strobe", t_stb, rt_stb);
      if (rt_stb) begin
        chk(t_addr == rt_addr, "R2 address", t_addr, rt_addr);
        chk(t_data == rt_data, "R5 data", t_data, rt_data);
      end
      chk(t_busy == rt_busy, "R8 busy", t_busy, rt_busy);
      chk(t_byp == rt_byp, "R3 bypass flag", t_byp, rt_byp);
      chk(t_asel == rt_asel, "R6 autoselect flag", t_asel, rt_asel);
      chk(t_code == code_exp(rt_asel, 1, addr, wp_n), "R6 code", t_code, code_exp(rt_asel, 1, addr, wp_n));
      chk(b_stb == rb_stb, "R7 bottom strobe", b_stb, rb_stb);
      chk(b_busy == rb_busy, "R7 bottom busy", b_busy, rb_busy);
      chk(b_byp == rb_byp && b_asel == rb_asel, "R6 bottom modes", {b_byp, b_asel}, {rb_byp, rb_asel});
      chk(b_code == code_exp(rb_asel, 0, addr, wp_n), "R6 bottom code", b_code, code_exp(rb_asel, 0, addr, wp_n));
      if (t_stb) begin
        stb_seen++;
        last_addr = t_addr;
        last_data = t_data;
        last_bt   = t_busy;
        last_bb   = b_busy;
      end
    end
  end

  task automatic cyc(int n = 1);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic wrx(logic [AW-1:0] a, logic [31:0] d, logic ce_v, logic oe_v);
    ce_n = ce_v; we_n = 0; oe_n = oe_v; addr = a; wdata = d;
    cyc();
    we_n = 1;
    cyc();
    ce_n = 1; oe_n = 1;
    cyc();
  endtask

  task automatic wr(logic [AW-1:0] a, logic [31:0] d);
    wrx(a, d, 1'b0, 1'b1);
  endtask

  task automatic unlock();
    wr(19'h555, 32'hAA);
    wr(19'h2AA, 32'h55);
  endtask

  task automatic prog(logic [AW-1:0] a, logic [31:0] d);
    unlock();
    wr(19'h555, 32'hA0);
    wr(a, d);
  endtask

  task automatic rd(logic [AW-1:0] a);
    ce_n = 0; oe_n = 0; we_n = 1; addr = a;
    cyc();
  endtask

  task automatic settle();
    ce_n = 1; oe_n = 1;
    cyc(ERS_CYC + 2);
  endtask

  task automatic finish_up();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog R1 actual=hung expected=finished");
      finish_up();
    end
  end

  initial begin
    int n0;
    cyc(4);
    rst_n = 1;
    cyc();
    chk(t_busy == 2'b00 && !t_stb, "R8 reset busy", t_busy, 0);
    chk(!t_byp && !t_asel, "R3 reset modes", {t_byp, t_asel}, 0);

    n0 = stb_seen;
    prog(19'h01234, 32'hDEADBEEF);
    chk(stb_seen == n0 + 1, "R2 strobe count", stb_seen - n0, 1);
    chk(last_addr == 19'h01234, "R2 address", last_addr, 19'h01234);
    chk(last_data == 32'hDEADBEEF, "R5 x32 data", last_data, 32'hDEADBEEF);
    chk(last_bt == 2'b01, "R8 bank0 busy at strobe", last_bt, 2'b01);
    cyc(3);
    chk(t_busy == 2'b01, "R8 last busy cycle", t_busy, 2'b01);
    cyc(1);
    chk(t_busy == 2'b00, "R8 busy ended", t_busy, 2'b00);
    settle();

    x16 = 1;
    prog(19'h40010, 32'h12345678);
    chk(last_data == 32'h00005678, "R5 x16 data", last_data, 32'h00005678);
    chk(last_bt == 2'b10, "R7 top bank1", last_bt, 2'b10);
    chk(last_bb == 2'b01, "R7 bottom bank0", last_bb, 2'b01);
    x16 = 0;
    settle();
    prog(19'h60000, 32'h1);
    chk(last_bt == 2'b10 && last_bb == 2'b10, "R7 addr top 11", {last_bt, last_bb}, 4'b1010);
    settle();
    prog(19'h00040, 32'h2);
    chk(last_bt == 2'b01 && last_bb == 2'b01, "R7 addr top 00", {last_bt, last_bb}, 4'b0101);
    settle();

    unlock();
    wr(19'h555, 32'h90);
    rd(19'h00000);
    chk(t_code == 8'h01, "R6 maker code", t_code, 8'h01);
    rd(19'h00001);
    chk(t_code == 8'h3A, "R6 device code", t_code, 8'h3A);
    wp_n = 0;
    rd(19'h7F002);
    chk(t_code == 8'h01, "R6 protect status top", t_code, 8'h01);
    rd(19'h00002);
    chk(t_code == 8'h00 && b_code == 8'h01, "R6 protect status per boot", {t_code, b_code}, 16'h0001);
    wp_n = 1;
    settle();
    wr(19'h0, 32'hF0);
    chk(!t_asel, "R6 leave autoselect", t_asel, 0);

    unlock();
    wr(19'h555, 32'h20);
    chk(t_byp, "R3 bypass entered", t_byp, 1);
    n0 = stb_seen;
    wr(19'h0, 32'hA0);
    wr(19'h00100, 32'hCAFE0001);
    chk(stb_seen == n0 + 1 && last_data == 32'hCAFE0001, "R3 bypass program", last_data, 32'hCAFE0001);
    settle();
    wr(19'h0, 32'h90);
    wr(19'h0, 32'h11);
    chk(t_byp, "R11 bad exit stays bypass", t_byp, 1);
    wr(19'h0, 32'h90);
    wr(19'h0, 32'h00);
    chk(!t_byp, "R3 bypass exit", t_byp, 0);

    acc_hi = 1;
    cyc();
    chk(t_byp, "R4 accel bypass", t_byp, 1);
    n0 = stb_seen;
    wr(19'h0, 32'hA0);
    wr(19'h00200, 32'h55AA);
    chk(stb_seen == n0 + 1 && last_addr == 19'h00200, "R4 accel program", last_addr, 19'h00200);
    settle();
    wr(19'h0, 32'h90);
    wr(19'h0, 32'h00);
    chk(t_byp, "R4 no exit under accel", t_byp, 1);
    wp_n = 0;
    n0 = stb_seen;
    wr(19'h0, 32'hA0);
    wr(19'h7F010, 32'h1);
    chk(stb_seen == n0 && t_busy == 2'b00, "R10 accel protected", stb_seen - n0, 0);
    wp_n = 1;
    acc_hi = 0;
    settle();
    wr(19'h0, 32'h90);
    wr(19'h0, 32'h00);
    chk(!t_byp, "R4 exit after accel", t_byp, 0);

    wp_n = 0;
    n0 = stb_seen;
    prog(19'h7F010, 32'h7);
    chk(stb_seen == n0 && t_busy == 2'b00, "R10 program protected", t_busy, 0);
    unlock();
    wr(19'h555, 32'h80);
    unlock();
    wr(19'h7F000, 32'h30);
    chk(t_busy == 2'b00, "R10 erase protected", t_busy, 0);
    wp_n = 1;
    settle();

    unlock();
    wr(19'h555, 32'h80);
    unlock();
    wr(19'h00000, 32'h30);
    chk(t_busy == 2'b01, "R9 sector erase busy", t_busy, 2'b01);
    cyc(ERS_CYC - 3);
    chk(t_busy == 2'b01, "R9 sector erase length", t_busy, 2'b01);
    cyc(1);
    chk(t_busy == 2'b00, "R9 sector erase end", t_busy, 2'b00);
    unlock();
    wr(19'h555, 32'h80);
    unlock();
    wr(19'h555, 32'h10);
    chk(t_busy == 2'b11, "R9 chip erase", t_busy, 2'b11);
    settle();

    n0 = stb_seen;
    wr(19'h555, 32'hAA);
    wr(19'h2AA, 32'h54);
    wr(19'h555, 32'hA0);
    wr(19'h00300, 32'h9);
    chk(stb_seen == n0 && t_busy == 2'b00, "R11 bad unlock", stb_seen - n0, 0);
    wr(19'h555, 32'hAA);
    wr(19'h0, 32'hF0);
    wr(19'h2AA, 32'h55);
    wr(19'h555, 32'hA0);
    wr(19'h00300, 32'h9);
    chk(stb_seen == n0, "R11 reset mid sequence", stb_seen - n0, 0);

    n0 = stb_seen;
    prog(19'h00400, 32'h1);
    prog(19'h40400, 32'h2);
    chk(stb_seen == n0 + 1, "R12 writes ignored while busy", stb_seen - n0, 1);
    settle();

    n0 = stb_seen;
    wrx(19'h555, 32'hAA, 1'b0, 1'b0);
    wrx(19'h2AA, 32'h55, 1'b0, 1'b0);
    wrx(19'h555, 32'hA0, 1'b0, 1'b0);
    wrx(19'h00500, 32'h3, 1'b0, 1'b0);
    wrx(19'h555, 32'hAA, 1'b1, 1'b1);
    wr(19'h2AA, 32'h55);
    wr(19'h555, 32'hA0);
    wr(19'h00500, 32'h3);
    chk(stb_seen == n0, "R1 gated writes", stb_seen - n0, 0);
    ce_n = 0; we_n = 0; oe_n = 1; addr = 19'h555; wdata = 32'hAA;
    cyc(4);
    we_n = 1;
    cyc();
    ce_n = 1;
    cyc();
    wr(19'h2AA, 32'h55);
    wr(19'h555, 32'hA0);
    wr(19'h00500, 32'h3);
    chk(stb_seen == n0 + 1, "R1 held write counts once", stb_seen - n0, 1);
    settle();

    finish_up();
  end
endmodule